// File: doc/BRIEF.md
# Receive Pipe Transaction Counter

This block counts the data packets that arrive on one receive pipe of a USB-style host/function controller. Software loads a packet total and then sets an enable bit. From that point the block counts each packet-received strobe. When the count equals the total, the run is complete, and the block can start three end-of-transfer actions. Each action is chosen by its own option bit:

- an early buffer handover to the CPU side in continuous mode;
- a request that forces the pipe's handshake to NAK;
- a buffer-ready interrupt that waits until the CPU has read the last received data.

A run is armed by a 0-to-1 edge of the enable bit or by a clear strobe. Either one resets the count and samples the total. The count then stops at the total, and each action fires at most once until the next arming. When the pipe direction is transmit, the block stays idle.

Top module: `rx_xact_counter`

## Requirements
- R1: After a synchronous active-low reset, `cur_count` is 0 and `switch_req`, `nak_req` and `rdy_irq` are 0.
- R2: A `pkt_rcvd` strobe increments `cur_count` by one in the next cycle, but only while `cfg_enable` is 1. Strobes received while `cfg_enable` is 0 leave the count unchanged.
- R3: The packet total is sampled from `cfg_target` when the block is armed. Arming happens at a 0-to-1 edge of `cfg_enable` or at a `clr_strobe`, and also sets the count to 0. Changes to `cfg_target` between armings have no effect.
- R4: A run completes on the packet that makes the count equal to the sampled total. The count then saturates: further packets leave it at the total.
- R5: When `opt_cont` is 1 and `buf_full` is 0 in the completing cycle, `switch_req` is 1 for exactly one cycle, in the cycle after the completing packet strobe. Otherwise it stays 0.
- R6: When `opt_short_nak` is 1, `nak_req` is 1 for exactly one cycle, in the cycle after the completing packet strobe.
- R7: When `opt_rdy_end` is 1, `rdy_irq` pulses for one cycle after the first `last_read` strobe that follows completion. A `last_read` before completion or in the completing cycle has no effect. A second `last_read` gives no further pulse.
- R8: `clr_strobe` sets the count to 0 in the next cycle, even when a packet strobe arrives in the same cycle. The clear re-arms the run, so the actions can fire again.
- R9: While `dir_tx` is 1, packets are not counted and no action output is raised.
- R10: A sampled total of 0 never completes: the count stays 0 and no action fires.
- R11: Dropping `cfg_enable` to 0 before the deferred interrupt is released cancels it. A later `last_read` gives no `rdy_irq` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_target | input | 16 | Packet total to be reached |
| cfg_enable | input | 1 | Counter enable bit |
| clr_strobe | input | 1 | One-cycle write-1 clear of the count (self-clearing) |
| opt_cont | input | 1 | Continuous-mode option: early buffer handover |
| opt_short_nak | input | 1 | Force-NAK-on-completion option |
| opt_rdy_end | input | 1 | Deferred ready interrupt option |
| dir_tx | input | 1 | Pipe direction, 1 = transmit |
| pkt_rcvd | input | 1 | One-cycle strobe per received packet |
| buf_full | input | 1 | Receive buffer is already full |
| last_read | input | 1 | CPU has read the last received data |
| cur_count | output | 16 | Current packet count |
| switch_req | output | 1 | Buffer handover request pulse |
| nak_req | output | 1 | Force-NAK request pulse |
| rdy_irq | output | 1 | Buffer-ready interrupt pulse |

## Verification
A corrupted count shows on `cur_count` in the cycle after the faulty packet. It also moves the `switch_req` and `nak_req` pulses earlier, later, or removes them, which appears at the completing packet. A wrongly latched total changes which packet completes the run, so the test sweeps each small total under every option combination. A stale pending-interrupt flag shows only at the next `last_read` strobe, so the test checks that strobe before completion, after completion, a second time, and after the enable is dropped.

// File: rtl/rxc_pkg.sv
// Shared types for the receive pipe transaction counter.
package rxc_pkg;
    // Completion action selectors.
    typedef struct packed {
        logic cont;
        logic short_nak;
        logic rdy_end;
    } rxc_opts_t;
endpackage

// File: rtl/rxc_arm.sv
// Arming logic: detects the enable rising edge or a clear, and samples the
// packet total at that moment.
// Assumes clr is a one-cycle strobe and that the enable bit is set before
// the first packet to be counted.
module rxc_arm #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             dir_tx,
    input  logic             clr,
    input  logic [CNT_W-1:0] target,
    output logic             load,
    output logic             run_ok,
    output logic [CNT_W-1:0] tgt_q
);
    logic en_q;

    assign load   = clr || (enable && !en_q);
    assign run_ok = enable && !dir_tx;

    // Delay the enable bit for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= enable;
    end

    // Sample the total only when arming.
    always_ff @(posedge clk) begin
        if (!rst_n)    tgt_q <= '0;
        else if (load) tgt_q <= target;
    end

    a_r3_target_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(tgt_q));
endmodule

// File: rtl/rxc_count.sv
// Packet counter: resets on arming and saturates at the sampled total.
// Also flags the completing step. Assumes a total of 0 means no completion.
module rxc_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run_ok,
    input  logic             pkt,
    input  logic [CNT_W-1:0] tgt,
    output logic [CNT_W-1:0] count,
    output logic             hit
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic step;

    assign step = run_ok && pkt && !load && (tgt != '0) && (count != tgt);
    assign hit  = step && ((count + ONE) == tgt);

    // Count packets; arming has priority over a packet in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (load) count <= '0;
        else if (step) count <= count + ONE;
    end

    a_r4_count_within_target: assert property (@(posedge clk) disable iff (!rst_n)
        count <= tgt);
    a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == '0));
    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_ok && !load) |=> $stable(count));
endmodule

// File: rtl/rxc_actions.sv
// Completion actions: handover and NAK pulses on completion, plus a ready
// interrupt deferred until the last data has been read.
// Assumes hit is high for at most one cycle per armed run.
module rxc_actions
    import rxc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hit,
    input  logic      load,
    input  logic      run_ok,
    input  rxc_opts_t opts,
    input  logic      buf_full,
    input  logic      last_read,
    output logic      switch_req,
    output logic      nak_req,
    output logic      rdy_irq
);
    logic pending;

    // Track a ready interrupt waiting for the final read.
    always_ff @(posedge clk) begin
        if (!rst_n)                pending <= 1'b0;
        else if (!run_ok || load)  pending <= 1'b0;
        else if (hit)              pending <= opts.rdy_end;
        else if (last_read)        pending <= 1'b0;
    end

    // Register one-cycle action pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            switch_req <= 1'b0;
            nak_req    <= 1'b0;
            rdy_irq    <= 1'b0;
        end else begin
            switch_req <= hit && opts.cont && !buf_full;
            nak_req    <= hit && opts.short_nak;
            rdy_irq    <= run_ok && !load && pending && last_read;
        end
    end

    a_r5_switch_single: assert property (@(posedge clk) disable iff (!rst_n)
        switch_req |=> !switch_req);
    a_r6_nak_single: assert property (@(posedge clk) disable iff (!rst_n)
        nak_req |=> !nak_req);
    a_r7_irq_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_irq |-> $past(last_read));
endmodule

// File: rtl/rx_xact_counter.sv
// Receive pipe transaction counter top level. Ties together arming, counting
// and the completion actions. Assumes single-cycle strobes for pkt_rcvd,
// clr_strobe and last_read.
module rx_xact_counter
    import rxc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_target,
    input  logic             cfg_enable,
    input  logic             clr_strobe,
    input  logic             opt_cont,
    input  logic             opt_short_nak,
    input  logic             opt_rdy_end,
    input  logic             dir_tx,
    input  logic             pkt_rcvd,
    input  logic             buf_full,
    input  logic             last_read,
    output logic [CNT_W-1:0] cur_count,
    output logic             switch_req,
    output logic             nak_req,
    output logic             rdy_irq
);
    logic             load;
    logic             run_ok;
    logic             hit;
    logic [CNT_W-1:0] tgt_q;
    rxc_opts_t        opts;

    assign opts = '{cont: opt_cont, short_nak: opt_short_nak, rdy_end: opt_rdy_end};

    rxc_arm #(.CNT_W(CNT_W)) u_arm (
        .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .dir_tx(dir_tx),
        .clr(clr_strobe), .target(cfg_target), .load(load), .run_ok(run_ok),
        .tgt_q(tgt_q)
    );

    rxc_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .load(load), .run_ok(run_ok), .pkt(pkt_rcvd),
        .tgt(tgt_q), .count(cur_count), .hit(hit)
    );

    rxc_actions u_actions (
        .clk(clk), .rst_n(rst_n), .hit(hit), .load(load), .run_ok(run_ok),
        .opts(opts), .buf_full(buf_full), .last_read(last_read),
        .switch_req(switch_req), .nak_req(nak_req), .rdy_irq(rdy_irq)
    );

    a_r9_tx_silent: assert property (@(posedge clk) disable iff (!rst_n)
        dir_tx |=> (!switch_req && !nak_req && !rdy_irq));
    a_r11_off_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !rdy_irq);
endmodule

// File: tb/rx_xact_counter_bench.sv
module rx_xact_counter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_target = '0;
    logic        cfg_enable = 1'b0, clr_strobe = 1'b0;
    logic        opt_cont = 1'b0, opt_short_nak = 1'b0, opt_rdy_end = 1'b0;
    logic        dir_tx = 1'b0, pkt_rcvd = 1'b0, buf_full = 1'b0, last_read = 1'b0;
    logic [15:0] cur_count;
    logic        switch_req, nak_req, rdy_irq;
    int total = 0, bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    rx_xact_counter u_rx_xact_counter (
        .clk(clk), .rst_n(rst_n), .cfg_target(cfg_target), .cfg_enable(cfg_enable),
        .clr_strobe(clr_strobe), .opt_cont(opt_cont), .opt_short_nak(opt_short_nak),
        .opt_rdy_end(opt_rdy_end), .dir_tx(dir_tx), .pkt_rcvd(pkt_rcvd),
        .buf_full(buf_full), .last_read(last_read), .cur_count(cur_count),
        .switch_req(switch_req), .nak_req(nak_req), .rdy_irq(rdy_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Each strobe task leaves time at the following falling edge,
    // where the registered result of the strobe is visible.
    task automatic pkt();
        @(negedge clk) pkt_rcvd = 1'b1;
        @(negedge clk) pkt_rcvd = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk) last_read = 1'b1;
        @(negedge clk) last_read = 1'b0;
    endtask

    task automatic clr(input bit with_pkt);
        @(negedge clk) begin clr_strobe = 1'b1; pkt_rcvd = with_pkt; end
        @(negedge clk) begin clr_strobe = 1'b0; pkt_rcvd = 1'b0; end
    endtask

    task automatic arm(input int tgt);
        @(negedge clk) begin cfg_enable = 1'b0; cfg_target = 16'(tgt); end
        @(negedge clk) cfg_enable = 1'b1;
        @(negedge clk);
    endtask

    task automatic acts(input string req, input int sw, input int nk, input int ri);
        chk({req, " switch_req"}, int'(switch_req), sw);
        chk({req, " nak_req"}, int'(nak_req), nk);
        chk({req, " rdy_irq"}, int'(rdy_irq), ri);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R1 watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 count", int'(cur_count), 0);
        acts("R1", 0, 0, 0);

        // R2: packets while disabled are not counted
        pkt(); pkt();
        chk("R2 disabled count", int'(cur_count), 0);

        // Sweep: totals 1..5, all option combinations (R4 R5 R6 R7)
        for (int t = 1; t <= 5; t++) begin
            for (int o = 0; o < 8; o++) begin
                opt_cont = o[0]; opt_short_nak = o[1]; opt_rdy_end = o[2];
                buf_full = t[0] & o[0];
                arm(t);
                chk("R3 armed count", int'(cur_count), 0);
                rd();
                chk("R7 early read", int'(rdy_irq), 0);
                for (int k = 1; k <= t + 2; k++) begin
                    pkt();
                    chk("R4 count", int'(cur_count), (k < t) ? k : t);
                    acts("R5/R6 pulse", (k == t && o[0] && !buf_full) ? 1 : 0,
                         (k == t && o[1]) ? 1 : 0, 0);
                end
                rd();
                chk("R7 deferred irq", int'(rdy_irq), o[2] ? 1 : 0);
                rd();
                chk("R7 second read", int'(rdy_irq), 0);
            end
        end
        opt_cont = 1'b1; opt_short_nak = 1'b1; opt_rdy_end = 1'b1; buf_full = 1'b0;

        // R3: target write after arming ignored
        arm(3);
        cfg_target = 16'd1;
        pkt();
        chk("R3 late target", int'(cur_count), 1);
        acts("R3 no early completion", 0, 0, 0);
        pkt(); pkt();
        acts("R3 completion at 3", 1, 1, 0);

        // R8: clear re-arms with new total; clear beats packet
        clr(1'b1);
        chk("R8 clear wins", int'(cur_count), 0);
        acts("R8 no pulse on clear", 0, 0, 0);
        pkt();
        chk("R8 rearmed count", int'(cur_count), 1);
        acts("R8 rearmed completion", 1, 1, 0);

        // R9: transmit direction stays idle
        arm(2);
        pkt();
        dir_tx = 1'b1;
        pkt(); pkt();
        chk("R9 tx count", int'(cur_count), 1);
        acts("R9 tx silent", 0, 0, 0);
        dir_tx = 1'b0;
        pkt();
        chk("R9 rx resumes", int'(cur_count), 2);
        acts("R9 completion after tx", 1, 1, 0);

        // R11: disable cancels pending interrupt
        @(negedge clk) cfg_enable = 1'b0;
        rd();
        chk("R11 cancelled irq", int'(rdy_irq), 0);
        @(negedge clk) cfg_enable = 1'b1;
        @(negedge clk);
        chk("R3 fresh enable rearms", int'(cur_count), 0);

        // R10: total of zero never completes
        arm(0);
        pkt(); pkt(); pkt();
        chk("R10 zero total count", int'(cur_count), 0);
        acts("R10 no actions", 0, 0, 0);
        rd();
        chk("R10 no irq", int'(rdy_irq), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule